// File: doc/BRIEF.md
# Pixel-Count Sync Regenerator

This block produces a local horizontal sync pulse by counting cycles of a recovered pixel-rate clock, and measures how that pulse sits against the incoming active-low composite sync. A line counter wraps at a programmed terminal count. A registered pulse shaper then drives a local sync of programmed start position and width. The input sync passes through a two-stage synchronizer and is edge-detected. A digital phase-frequency detector then reports, on a pair of up/down outputs, which of the two edges arrived first and by how many clocks.

The up/down pair is meant to steer an external loop filter and oscillator, which set the frequency of the count clock. Once enough consecutive lines show a small error, the loop is flagged as locked. The analog filter, the oscillator and the level translation lie outside this block.

Top module: `line_sync_regen`

## Requirements
- R1: While reset is active and in the first cycle after its release, `hsyncOut`, `phaseUp`, `phaseDown` and `locked` are all 0.
- R2: With constant settings, successive rising edges of `hsyncOut` are exactly `lineTotal`+1 clock cycles apart.
- R3: Each `hsyncOut` pulse is high for exactly `pulseWidth` cycles. A `pulseWidth` of 0 produces no pulse.
- R4: After reset is released, the first rising edge of `hsyncOut` is made by clock edge number `pulseStart`+1. The counter holds 0 until the first edge after release.
- R5: Define a coincident input as a falling edge of `csyncN` that is set up for clock edge k, where `hsyncOut` rises at edge k+1. If the input falls d cycles later than coincident, `phaseDown` is high for exactly d cycles and `phaseUp` stays low.
- R6: If the input falls d cycles earlier than coincident, `phaseUp` is high for exactly d cycles and `phaseDown` stays low.
- R7: A coincident input leaves both `phaseUp` and `phaseDown` low, and the two are never high together.
- R8: `locked` rises after `LOCK_LINES` (default 16) consecutive resolved edge pairs whose error is at most `TOL` (default 1) cycles.
- R9: Once the flagged error exceeds `TOL` cycles, `locked` goes low in the next cycle and the count of good lines restarts from zero.
- R10: If an incoming sync edge is missing, the open `phaseDown` interval grows past `TOL`, which clears `locked`. The line on which the input resumes does not count as a good line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered pixel-rate count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csyncN | input | 1 | Incoming composite sync, active low, asynchronous |
| lineTotal | input | CNT_W | Pixel count at which the line counter wraps (line length minus one) |
| pulseStart | input | CNT_W | Count value that starts the local sync pulse |
| pulseWidth | input | CNT_W | Local sync pulse width in cycles |
| hsyncOut | output | 1 | Regenerated horizontal sync, active high |
| phaseUp | output | 1 | Incoming edge leads: raise the oscillator frequency |
| phaseDown | output | 1 | Incoming edge lags: lower the oscillator frequency |
| locked | output | 1 | Phase error has stayed small over enough lines |

## Verification
Four line geometries are swept, covering short and long lines, early and late pulse positions, a one-cycle pulse and a zero-width pulse. In each geometry the incoming sync is shifted line by line through offsets of 0, +1, -1, +3 and -2, and one line has the input missing. The positive and negative offsets separate the up path from the down path. The one-cycle offsets sit exactly on the lock tolerance, while the larger ones must break lock. The missing line and the line on which the input resumes show how the detector recovers from an edge that never arrived.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;

  // Strobes from the line control to the line datapath.
  typedef struct packed {
    logic restartLine;  // counter is at its terminal value
    logic pulseOn;      // start the local sync pulse next cycle
    logic pulseEnd;     // last cycle of the local sync pulse
  } lineStrobe_t;

endpackage

// File: rtl/line_timing_ctl.sv
module line_timing_ctl
  import sync_regen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] pixCnt,
  input  logic [CNT_W-1:0] pulseLeft,
  input  logic             hsyncReg,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic [CNT_W-1:0] pulseStart,
  input  logic [CNT_W-1:0] pulseWidth,
  output lineStrobe_t      strobe
);

  logic widthNonZero;

  always_comb begin
    widthNonZero       = (pulseWidth != '0);
    strobe.restartLine = (pixCnt == lineTotal);
    strobe.pulseOn     = widthNonZero && (pixCnt == pulseStart);
    strobe.pulseEnd    = hsyncReg && (pulseLeft == '0) && !strobe.pulseOn;
  end

endmodule

// File: rtl/line_timing_dp.sv
module line_timing_dp
  import sync_regen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lineStrobe_t      strobe,
  input  logic [CNT_W-1:0] pulseWidth,
  output logic [CNT_W-1:0] pixCnt,
  output logic [CNT_W-1:0] pulseLeft,
  output logic             hsyncReg
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Pixel counter along the line.
  always_ff @(posedge clk) begin
    if (!rst_n)                  pixCnt <= '0;
    else if (strobe.restartLine) pixCnt <= '0;
    else                         pixCnt <= pixCnt + ONE;
  end

  // Pulse shaper: a register set by the start strobe, held by a down-counter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsyncReg  <= 1'b0;
      pulseLeft <= '0;
    end else if (strobe.pulseOn) begin
      hsyncReg  <= 1'b1;
      pulseLeft <= pulseWidth - ONE;
    end else if (strobe.pulseEnd) begin
      hsyncReg  <= 1'b0;
    end else if (hsyncReg) begin
      pulseLeft <= pulseLeft - ONE;
    end
  end

endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det #(
  parameter int CNT_W      = 10,
  parameter int LOCK_LINES = 16,
  parameter int TOL        = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csyncN,
  input  logic hsyncReg,
  output logic phaseUp,
  output logic phaseDown,
  output logic locked
);

  localparam int RUN_W  = CNT_W + 1;
  localparam int LOCK_W = $clog2(LOCK_LINES + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = '1;
  localparam logic [RUN_W-1:0]  TOL_V    = RUN_W'(TOL);
  localparam logic [LOCK_W-1:0] LOCK_TOP = LOCK_W'(LOCK_LINES);

  logic csMeta, csSync, csPrev, hsPrev;
  logic refEdge, locEdge, upNext, downNext, resolve, overErr, goodLine;
  logic [RUN_W-1:0]  runLen, lineErr;
  logic [LOCK_W-1:0] goodCnt, goodNext;

  // Two-stage synchronizer plus edge history; idle level is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csMeta <= 1'b1;
      csSync <= 1'b1;
      csPrev <= 1'b1;
      hsPrev <= 1'b0;
    end else begin
      csMeta <= csyncN;
      csSync <= csMeta;
      csPrev <= csSync;
      hsPrev <= hsyncReg;
    end
  end

  always_comb begin
    refEdge  = csPrev && !csSync;
    locEdge  = hsyncReg && !hsPrev;
    upNext   = phaseUp || refEdge;
    downNext = phaseDown || locEdge;
    resolve  = upNext && downNext;
    lineErr  = runLen + RUN_W'(phaseUp || phaseDown);
    overErr  = (lineErr > TOL_V);
    goodLine = resolve && !overErr;
    if (overErr || (resolve && !goodLine))
      goodNext = '0;
    else if (goodLine && (goodCnt != LOCK_TOP))
      goodNext = goodCnt + LOCK_W'(1);
    else
      goodNext = goodCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseUp   <= 1'b0;
      phaseDown <= 1'b0;
      runLen    <= '0;
      goodCnt   <= '0;
      locked    <= 1'b0;
    end else begin
      phaseUp   <= upNext && !resolve;
      phaseDown <= downNext && !resolve;
      if (resolve)
        runLen <= '0;
      else if ((phaseUp || phaseDown) && (runLen != RUN_MAX))
        runLen <= runLen + RUN_W'(1);
      goodCnt <= goodNext;
      locked  <= (goodNext == LOCK_TOP);
    end
  end

endmodule

// File: rtl/line_sync_regen.sv
module line_sync_regen
  import sync_regen_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LOCK_LINES = 16,
  parameter int TOL        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csyncN,
  input  logic [CNT_W-1:0] lineTotal,
  input  logic [CNT_W-1:0] pulseStart,
  input  logic [CNT_W-1:0] pulseWidth,
  output logic             hsyncOut,
  output logic             phaseUp,
  output logic             phaseDown,
  output logic             locked
);

  lineStrobe_t      strobe;
  logic [CNT_W-1:0] pixCnt, pulseLeft;
  logic             hsyncReg;

  line_timing_ctl #(.CNT_W(CNT_W)) u_ctl (
    .pixCnt(pixCnt), .pulseLeft(pulseLeft), .hsyncReg(hsyncReg),
    .lineTotal(lineTotal), .pulseStart(pulseStart), .pulseWidth(pulseWidth),
    .strobe(strobe)
  );

  line_timing_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pulseWidth(pulseWidth),
    .pixCnt(pixCnt), .pulseLeft(pulseLeft), .hsyncReg(hsyncReg)
  );

  phase_lock_det #(.CNT_W(CNT_W), .LOCK_LINES(LOCK_LINES), .TOL(TOL)) u_pld (
    .clk(clk), .rst_n(rst_n), .csyncN(csyncN), .hsyncReg(hsyncReg),
    .phaseUp(phaseUp), .phaseDown(phaseDown), .locked(locked)
  );

  assign hsyncOut = hsyncReg;

endmodule

// File: rtl/line_sync_regen_chk.sv
module line_sync_regen_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] lineTotal,
  input logic [CNT_W-1:0] pulseWidth,
  input logic             hsyncOut,
  input logic             phaseUp,
  input logic             phaseDown,
  input logic             locked
);

  localparam int GAP_W = CNT_W + 1;

  logic             hsPrevC, seenRise, riseNow;
  logic [GAP_W-1:0] sinceRise;

  assign riseNow = hsyncOut && !hsPrevC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsPrevC   <= 1'b0;
      seenRise  <= 1'b0;
      sinceRise <= '0;
    end else begin
      hsPrevC <= hsyncOut;
      if (riseNow) begin
        seenRise  <= 1'b1;
        sinceRise <= GAP_W'(1);
      end else if (sinceRise != '1) begin
        sinceRise <= sinceRise + GAP_W'(1);
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!hsyncOut && !phaseUp && !phaseDown && !locked));

  a_r2_line_period: assert property (@(posedge clk) disable iff (!rst_n)
    (riseNow && seenRise) |-> (sinceRise == ({1'b0, lineTotal} + GAP_W'(1))));

  a_r3_zero_width_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsyncOut) |-> (pulseWidth != '0));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(phaseUp && phaseDown));

  a_r8_lock_on_clean_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!phaseUp && !phaseDown));

  a_r9_long_error_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((phaseUp || phaseDown) && $past(phaseUp || phaseDown)) |=> !locked);

endmodule

bind line_sync_regen line_sync_regen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lineTotal(lineTotal), .pulseWidth(pulseWidth),
  .hsyncOut(hsyncOut), .phaseUp(phaseUp), .phaseDown(phaseDown), .locked(locked)
);

// File: tb/line_sync_regen_test.sv
module line_sync_regen_test;

  localparam int CW    = 10;
  localparam int LINES = 46;
  localparam int MISS  = 99;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csyncN = 1'b1;
  logic [CW-1:0] lineTotal = '0, pulseStart = '0, pulseWidth = '0;
  logic          hsyncOut, phaseUp, phaseDown, locked;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  line_sync_regen #(.CNT_W(CW), .LOCK_LINES(16), .TOL(1)) uut (
    .clk(clk), .rst_n(rst_n), .csyncN(csyncN),
    .lineTotal(lineTotal), .pulseStart(pulseStart), .pulseWidth(pulseWidth),
    .hsyncOut(hsyncOut), .phaseUp(phaseUp), .phaseDown(phaseDown), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offset of the incoming edge against the coincident position, per line.
  function automatic int offsetOf(input int ln);
    if (ln == 16) return 1;
    if (ln == 17) return -1;
    if (ln == 19) return 3;
    if (ln == 37) return -2;
    if (ln == 41) return MISS;
    return 0;
  endfunction

  task automatic runConfig(input int len, input int st, input int wd);
    int  goodCnt = 0;
    bit  prevMiss = 1'b0;
    @(negedge clk);
    rst_n      = 1'b0;
    csyncN     = 1'b1;
    lineTotal  = CW'(len - 1);
    pulseStart = CW'(st);
    pulseWidth = CW'(wd);
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!hsyncOut && !phaseUp && !phaseDown && !locked, "R1",
          {28'd0, hsyncOut, phaseUp, phaseDown, locked}, 0);
    rst_n = 1'b1;
    for (int ln = 0; ln < LINES; ln++) begin
      int d       = offsetOf(ln);
      bit miss    = (d == MISS);
      int hsCnt   = 0;
      int firstHi = -1;
      int upCnt   = 0;
      int dnCnt   = 0;
      bit good;
      bit expLock;
      for (int rel = 0; rel < len; rel++) begin
        if (hsyncOut) begin
          hsCnt++;
          if (firstHi < 0) firstHi = rel;
        end
        upCnt += int'(phaseUp);
        dnCnt += int'(phaseDown);
        if (rel == len - 1) begin
          good = !miss && !prevMiss && (d >= -1) && (d <= 1) && (wd > 0);
          goodCnt = good ? ((goodCnt < 16) ? goodCnt + 1 : 16) : 0;
          expLock = (goodCnt == 16);
          if (miss)       check(locked == expLock, "R10", int'(locked), int'(expLock));
          else if (good)  check(locked == expLock, "R8",  int'(locked), int'(expLock));
          else            check(locked == expLock, "R9",  int'(locked), int'(expLock));
        end
        csyncN = miss ? 1'b1 : !((rel >= st - 1 + d) && (rel <= st + 2 + d));
        @(negedge clk);
      end
      // R3: pulse width per line
      check(hsCnt == wd, "R3", hsCnt, wd);
      // R2 R4: rise at pulseStart+1 within every line, so the period equals the line length
      if (wd > 0) check(firstHi == st + 1, (ln == 0) ? "R4" : "R2", firstHi, st + 1);
      if (!miss && !prevMiss && wd > 0) begin
        if (d > 0) begin
          check(dnCnt == d && upCnt == 0, "R5", dnCnt * 100 + upCnt, d * 100);
        end else if (d < 0) begin
          check(upCnt == -d && dnCnt == 0, "R6", upCnt * 100 + dnCnt, -d * 100);
        end else begin
          check(upCnt == 0 && dnCnt == 0, "R7", upCnt * 100 + dnCnt, 0);
        end
      end
      prevMiss = miss;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    runConfig(40, 10, 5);
    runConfig(25, 4, 7);
    runConfig(64, 40, 1);
    runConfig(32, 8, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule